// File: doc/BRIEF.md
# Prefetch Jump Target Cache

This block sits in an instruction prefetch unit and holds the two instruction words found at the destination of the most recent cacheable jump. The prefetcher normally streams 16-bit words from memory in ascending address order. Memory answers a request one cycle after it is issued. When the execution stage reports a taken jump, the prefetcher moves its fetch pointer to the jump destination.

Three classes of jump can fill the entry: conditional relative, conditional absolute and bit-test jumps. The requester marks these with a class flag. On a miss the two destination words are captured as they come back from memory, and the entry is tagged with the address of the jump instruction. If the same jump is taken again before any other cacheable jump, the two stored words go to the decoder in the two cycles that follow, with no memory access. The prefetcher then continues from memory at the destination plus four bytes.

An interrupt entry or a branch or call to another code segment empties the entry. Code running from internal ROM or flash does not use the entry at all. The memory port can be taken away for whole cycles by a transfer engine. While that happens the fetch pointer waits, so the resume address is not disturbed.

Top module: `jtc_top`

## Requirements
- R1: While `rstN` is low `decValid` and `memReq` are 0. After reset, fetching starts at `RESET_ADDR`, and consecutive requests and delivered words advance by 2 bytes. Each memory word reaches `decValid`/`decWord`/`decAddr` one cycle after its request.
- R2: On a taken jump, no memory request is made in the jump cycle. On a miss, fetching restarts at the destination T, and the decoder next receives T and T+2 from memory.
- R3: A taken jump with `jmpLoads`=1 whose `jmpAddr` equals the tag of a fully filled entry is a hit. The words stored for T and T+2 are then delivered in the first and second cycles after the jump, even if memory now holds other data.
- R4: After the two stored words of a hit, the first memory request is to T+4, and the next delivered word is T+4.
- R5: A taken jump with `jmpLoads`=0 redirects fetching but leaves the entry unchanged, so a later repeat of the cached jump still hits.
- R6: A cacheable jump to a different jump address refills the entry. A later repeat of the earlier jump then misses and reads memory.
- R7: A pulse on `flushIrq` or `flushSeg` empties the entry. When a flush coincides with a jump, the flush wins: the jump misses and does not fill the entry.
- R8: A jump taken with `intRom`=1 neither hits nor fills, and it leaves the entry as it was.
- R9: In a cycle with `memBusy`=1 no request is issued and the fetch pointer holds. Stalls during a fill or after a hit still yield the correct words and resume at T+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| jmpTaken | input | 1 | A jump is taken this cycle |
| jmpLoads | input | 1 | The taken jump belongs to a cache-loading class |
| jmpAddr | input | AW | Address of the jump instruction |
| jmpTarget | input | AW | Jump destination byte address |
| intRom | input | 1 | Execution is from internal ROM/flash (bypass) |
| flushIrq | input | 1 | Interrupt entry: empty the entry |
| flushSeg | input | 1 | Inter-segment branch or call: empty the entry |
| memReq | output | 1 | Fetch request this cycle |
| memAddr | output | AW | Fetch byte address |
| memBusy | input | 1 | Memory port is occupied by a transfer this cycle |
| memRdata | input | WW | Word answering the previous cycle's request |
| decValid | output | 1 | A word is offered to the decoder |
| decWord | output | WW | Instruction word |
| decAddr | output | AW | Byte address of `decWord` |

## Verification
The bench changes the memory contents between a fill and its repeat jump. A hit therefore returns the old words, while a miss returns the new ones. A design that hit when it should miss, or missed when it should hit, shows the wrong data. Each hit is followed by a check of the next word. A design that resumes at T+2 would deliver a duplicated word, and one that skips too far would lose a word.

The bench also covers these interfering events, each of which a faulty design would answer with stale cached words:
- non-loading jumps;
- jumps from internal ROM;
- a flush alone;
- a flush in the same cycle as a jump;
- a replacing jump.

Port stalls are placed right after a hit and in the middle of a fill. They expose a fetch pointer that slips, and a fill that captures a word against the wrong address.

// File: rtl/jtc_pkg.sv
package jtc_pkg;

  // Strobes from the control to the datapath, one set per cycle.
  typedef struct packed {
    logic issue;         // memory request this cycle, advance fetch pointer
    logic redirect;      // load fetch pointer with jump destination
    logic redirectSkip;  // load fetch pointer with destination past the cached words
    logic startFill;     // capture tag and base, begin filling
    logic invalidate;    // empty the entry
    logic cacheSend;     // deliver a stored word this cycle
  } jtcStrobe_t;

endpackage

// File: rtl/jtc_control.sv
module jtc_control
  import jtc_pkg::*;
#(
  parameter int CW = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       jmpTaken,
  input  logic       jmpLoads,
  input  logic       intRom,
  input  logic       flushIrq,
  input  logic       flushSeg,
  input  logic       memBusy,
  input  logic       tagHit,
  output jtcStrobe_t strobe
);

  localparam int CNTW = $clog2(CW + 1);

  logic [CNTW-1:0] remQ, remD;
  logic            runQ;
  logic            flushAny, cacheable, hitNow;

  always_comb begin
    flushAny  = flushIrq | flushSeg;
    cacheable = jmpLoads && !intRom && !flushAny;
    hitNow    = jmpTaken && cacheable && tagHit;

    strobe              = '0;
    strobe.cacheSend    = (remQ != '0);
    // memory may be asked during the last stored word so it follows without a gap
    strobe.issue        = runQ && !jmpTaken && !memBusy && (remQ <= CNTW'(1));
    strobe.redirect     = jmpTaken && !hitNow;
    strobe.redirectSkip = hitNow;
    strobe.startFill    = jmpTaken && cacheable && !tagHit;
    strobe.invalidate   = flushAny;

    if (jmpTaken)
      remD = hitNow ? CNTW'(CW) : '0;
    else if (remQ != '0)
      remD = remQ - CNTW'(1);
    else
      remD = remQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remQ <= '0;
      runQ <= 1'b0;
    end else begin
      remQ <= remD;
      runQ <= 1'b1;
    end
  end

endmodule

// File: rtl/jtc_datapath.sv
module jtc_datapath
  import jtc_pkg::*;
#(
  parameter int          AW         = 16,
  parameter int          WW         = 16,
  parameter int          CW         = 2,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  jtcStrobe_t    strobe,
  input  logic [AW-1:0] jmpAddr,
  input  logic [AW-1:0] jmpTarget,
  input  logic [WW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic          tagHit,
  output logic          entryValid,
  output logic          decValid,
  output logic [WW-1:0] decWord,
  output logic [AW-1:0] decAddr
);

  localparam int            STEP   = WW / 8;
  localparam int            IW     = (CW > 1) ? $clog2(CW) : 1;
  localparam logic [AW-1:0] STEP_A = AW'(STEP);
  localparam logic [AW-1:0] SKIP_A = AW'(CW * STEP);

  logic [AW-1:0] fetchPtrQ, reqAddrQ, tagQ, baseQ;
  logic          reqPendQ, validQ, fillActQ;
  logic [IW-1:0] fillIdxQ, sendIdxQ;
  logic [AW-1:0] fillAddr;
  logic          fillHit, fillLast, fillWrite;
  logic [WW-1:0] wordArr [CW];

  assign fillAddr  = baseQ + AW'(fillIdxQ) * STEP_A;
  assign fillHit   = reqPendQ && fillActQ && (reqAddrQ == fillAddr);
  assign fillLast  = (fillIdxQ == IW'(CW - 1));
  assign fillWrite = fillHit && !strobe.invalidate && !strobe.startFill;

  // fetch pointer and outstanding request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchPtrQ <= RESET_ADDR;
      reqAddrQ  <= RESET_ADDR;
      reqPendQ  <= 1'b0;
    end else begin
      reqPendQ <= strobe.issue;
      if (strobe.issue) reqAddrQ <= fetchPtrQ;
      if (strobe.redirect)
        fetchPtrQ <= jmpTarget;
      else if (strobe.redirectSkip)
        fetchPtrQ <= jmpTarget + SKIP_A;
      else if (strobe.issue)
        fetchPtrQ <= fetchPtrQ + STEP_A;
    end
  end

  // entry tag, base and fill progress
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ   <= 1'b0;
      fillActQ <= 1'b0;
      fillIdxQ <= '0;
      tagQ     <= '0;
      baseQ    <= '0;
    end else if (strobe.invalidate) begin
      validQ   <= 1'b0;
      fillActQ <= 1'b0;
    end else if (strobe.startFill) begin
      validQ   <= 1'b0;
      fillActQ <= 1'b1;
      fillIdxQ <= '0;
      tagQ     <= jmpAddr;
      baseQ    <= jmpTarget;
    end else if (fillHit) begin
      if (fillLast) begin
        validQ   <= 1'b1;
        fillActQ <= 1'b0;
      end else begin
        fillIdxQ <= fillIdxQ + IW'(1);
      end
    end
  end

  // stored words, one register per slot
  for (genvar g = 0; g < CW; g++) begin : g_word
    logic [WW-1:0] wordQ;
    always_ff @(posedge clk) begin
      if (fillWrite && (fillIdxQ == IW'(g))) wordQ <= memRdata;
    end
    assign wordArr[g] = wordQ;
  end

  // index of the stored word being delivered
  always_ff @(posedge clk) begin
    if (!rstN)
      sendIdxQ <= '0;
    else if (strobe.redirectSkip)
      sendIdxQ <= '0;
    else if (strobe.cacheSend)
      sendIdxQ <= sendIdxQ + IW'(1);
  end

  assign memAddr    = fetchPtrQ;
  assign tagHit     = validQ && (tagQ == jmpAddr);
  assign entryValid = validQ;
  assign decValid   = strobe.cacheSend || reqPendQ;
  assign decWord    = strobe.cacheSend ? wordArr[sendIdxQ] : memRdata;
  assign decAddr    = strobe.cacheSend ? (baseQ + AW'(sendIdxQ) * STEP_A) : reqAddrQ;

endmodule

// File: rtl/jtc_top.sv
module jtc_top
  import jtc_pkg::*;
#(
  parameter int            AW         = 16,
  parameter int            WW         = 16,
  parameter int            CW         = 2,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          jmpTaken,
  input  logic          jmpLoads,
  input  logic [AW-1:0] jmpAddr,
  input  logic [AW-1:0] jmpTarget,
  input  logic          intRom,
  input  logic          flushIrq,
  input  logic          flushSeg,
  output logic          memReq,
  output logic [AW-1:0] memAddr,
  input  logic          memBusy,
  input  logic [WW-1:0] memRdata,
  output logic          decValid,
  output logic [WW-1:0] decWord,
  output logic [AW-1:0] decAddr
);

  jtcStrobe_t strobe;
  logic       tagHit;
  logic       entryValid;

  jtc_control #(.CW(CW)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .jmpTaken (jmpTaken),
    .jmpLoads (jmpLoads),
    .intRom   (intRom),
    .flushIrq (flushIrq),
    .flushSeg (flushSeg),
    .memBusy  (memBusy),
    .tagHit   (tagHit),
    .strobe   (strobe)
  );

  jtc_datapath #(.AW(AW), .WW(WW), .CW(CW), .RESET_ADDR(RESET_ADDR)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .jmpAddr    (jmpAddr),
    .jmpTarget  (jmpTarget),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .tagHit     (tagHit),
    .entryValid (entryValid),
    .decValid   (decValid),
    .decWord    (decWord),
    .decAddr    (decAddr)
  );

  assign memReq = strobe.issue;

endmodule

// File: rtl/jtc_checker.sv
module jtc_checker #(
  parameter int AW   = 16,
  parameter int STEP = 2,
  parameter int SKIP = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          jmpTaken,
  input logic          jmpLoads,
  input logic [AW-1:0] jmpTarget,
  input logic          intRom,
  input logic          flushIrq,
  input logic          flushSeg,
  input logic          memBusy,
  input logic          memReq,
  input logic [AW-1:0] memAddr,
  input logic          decValid,
  input logic [AW-1:0] decAddr,
  input logic          tagHit,
  input logic          entryValid
);

  logic hitCond;
  assign hitCond = jmpTaken && jmpLoads && !intRom && !flushIrq && !flushSeg && tagHit;

  // R1
  seq_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && $past(memReq)) |-> (memAddr == $past(memAddr) + AW'(STEP)));

  // R2
  jmp_noreq_chk: assert property (@(posedge clk) disable iff (!rstN)
    jmpTaken |-> !memReq);

  // R2
  miss_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (jmpTaken && !jmpLoads) |=> !decValid);

  // R3
  hit_deliver_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitCond |=> (decValid && (decAddr == $past(jmpTarget))));

  // R4
  resume_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(hitCond, 2) && memReq && !$past(jmpTaken) && !jmpTaken)
      |-> (memAddr == $past(jmpTarget, 2) + AW'(SKIP)));

  // R7
  flush_inval_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flushIrq || flushSeg) |=> !entryValid);

  // R8
  rom_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (jmpTaken && intRom) |=> !decValid);

  // R9
  busy_noreq_chk: assert property (@(posedge clk) disable iff (!rstN)
    memBusy |-> !memReq);

endmodule

bind jtc_top jtc_checker #(.AW(AW), .STEP(WW / 8), .SKIP(CW * (WW / 8))) u_jtcChk (
  .clk        (clk),
  .rstN       (rstN),
  .jmpTaken   (jmpTaken),
  .jmpLoads   (jmpLoads),
  .jmpTarget  (jmpTarget),
  .intRom     (intRom),
  .flushIrq   (flushIrq),
  .flushSeg   (flushSeg),
  .memBusy    (memBusy),
  .memReq     (memReq),
  .memAddr    (memAddr),
  .decValid   (decValid),
  .decAddr    (decAddr),
  .tagHit     (tagHit),
  .entryValid (entryValid)
);

// File: tb/test_jtc_top.sv
module test_jtc_top;

  localparam int AW = 16;
  localparam int WW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          jmpTaken = 1'b0, jmpLoads = 1'b0, intRom = 1'b0;
  logic          flushIrq = 1'b0, flushSeg = 1'b0, memBusy = 1'b0;
  logic [AW-1:0] jmpAddr = '0, jmpTarget = '0;
  logic          memReq, decValid;
  logic [AW-1:0] memAddr, decAddr;
  logic [WW-1:0] memRdata = '0, decWord;

  jtc_top #(.AW(AW), .WW(WW)) i_jtc_top (
    .clk(clk), .rstN(rstN), .jmpTaken(jmpTaken), .jmpLoads(jmpLoads),
    .jmpAddr(jmpAddr), .jmpTarget(jmpTarget), .intRom(intRom),
    .flushIrq(flushIrq), .flushSeg(flushSeg), .memReq(memReq), .memAddr(memAddr),
    .memBusy(memBusy), .memRdata(memRdata), .decValid(decValid),
    .decWord(decWord), .decAddr(decAddr)
  );

  always #10 clk = ~clk;  // 50 MHz

  // memory model: contents depend on a generation number the bench can change
  logic [7:0] gen = 8'd1;
  function automatic logic [WW-1:0] wordOf(input logic [AW-1:0] a, input logic [7:0] g);
    return a ^ {g, 8'h3C};
  endfunction
  always_ff @(posedge clk) if (memReq) memRdata <= wordOf(memAddr, gen);

  int nVec = 0, nBad = 0;
  bit done = 0;
  string curTag = "R1";

  // scoreboard queues
  logic [AW-1:0] qAddr[$];
  logic [WW-1:0] qWord[$];
  string         qTag[$];

  // bench model of the entry, kept from the requirements
  bit            mValid = 0;
  logic [AW-1:0] mTag = '0;
  logic [7:0]    mGen = '0;

  task automatic push(input logic [AW-1:0] a, input logic [WW-1:0] w, input string t);
    qAddr.push_back(a); qWord.push_back(w); qTag.push_back(t);
  endtask

  // monitor: compare delivered words against queued expectations, else the plain stream
  logic [AW-1:0] lastAddr = '0;
  bit haveLast = 0;
  always @(negedge clk) begin
    if (rstN && !done && decValid && !jmpTaken) begin
      nVec++;
      if (qAddr.size() > 0) begin
        logic [AW-1:0] ea;
        logic [WW-1:0] ew;
        string et;
        ea = qAddr.pop_front(); ew = qWord.pop_front(); et = qTag.pop_front();
        if (decAddr !== ea || decWord !== ew) begin
          nBad++;
          $display("FAIL %s: addr/word %h/%h expected %h/%h", et, decAddr, decWord, ea, ew);
        end
      end else if (haveLast) begin
        // R1 sequential stream from memory
        if (decAddr !== lastAddr + 16'd2 || decWord !== wordOf(decAddr, gen)) begin
          nBad++;
          $display("FAIL R1: stream addr/word %h/%h expected %h/%h",
                   decAddr, decWord, lastAddr + 16'd2, wordOf(lastAddr + 16'd2, gen));
        end
      end
      lastAddr = decAddr;
      haveLast = 1;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
    nVec++;
    if (qAddr.size() != 0) begin
      nBad++;
      $display("FAIL %s: %0d expected words never delivered (expected 0)", curTag, qAddr.size());
      qAddr.delete(); qWord.delete(); qTag.delete();
    end
  endtask

  // change memory contents while the port is held busy so nothing is in flight
  task automatic setGen(input logic [7:0] g);
    @(posedge clk); #1 memBusy = 1;
    repeat (2) @(posedge clk);
    #1 gen = g;
    @(posedge clk); #1 memBusy = 0;
    idle(3);
  endtask

  task automatic jump(input logic [AW-1:0] a, input logic [AW-1:0] t, input bit ld,
                      input bit rom, input bit fl, input int busyN, input string tag);
    bit hit;
    curTag = tag;
    @(posedge clk); #1;
    jmpTaken = 1; jmpAddr = a; jmpTarget = t; jmpLoads = ld; intRom = rom; flushIrq = fl;
    hit = ld && !rom && !fl && mValid && (mTag == a);
    if (hit) begin
      push(t, wordOf(t, mGen), tag);
      push(t + 16'd2, wordOf(t + 16'd2, mGen), tag);
      push(t + 16'd4, wordOf(t + 16'd4, gen), tag);
    end else begin
      push(t, wordOf(t, gen), tag);
      push(t + 16'd2, wordOf(t + 16'd2, gen), tag);
      if (ld && !rom && !fl) begin mValid = 1; mTag = a; mGen = gen; end
    end
    if (fl) mValid = 0;
    @(posedge clk); #1;
    jmpTaken = 0; jmpLoads = 0; intRom = 0; flushIrq = 0;
    if (busyN > 0) begin
      memBusy = 1;
      repeat (busyN) @(posedge clk);
      #1 memBusy = 0;
    end
    idle(10);
  endtask

  initial begin
    // R1 reset state
    repeat (3) begin
      @(negedge clk);
      nVec++;
      if (decValid !== 1'b0 || memReq !== 1'b0) begin
        nBad++;
        $display("FAIL R1: in reset decValid/memReq %b/%b expected 0/0", decValid, memReq);
      end
    end
    push(16'h0000, wordOf(16'h0000, gen), "R1");
    @(posedge clk); #1 rstN = 1;
    idle(8);

    jump(16'h0100, 16'h0400, 1, 0, 0, 0, "R2");          // R2 miss fills entry
    setGen(8'd2);
    jump(16'h0100, 16'h0400, 1, 0, 0, 0, "R3/R4");       // R3 hit with old words, R4 resume
    jump(16'h0150, 16'h0800, 0, 0, 0, 0, "R5");          // R5 non-loading jump
    jump(16'h0100, 16'h0400, 1, 0, 0, 0, "R5");          // R5 entry still hits
    jump(16'h0100, 16'h0400, 1, 1, 0, 0, "R8");          // R8 internal ROM bypasses
    setGen(8'd3);
    jump(16'h0100, 16'h0400, 1, 0, 0, 0, "R8");          // R8 entry untouched by bypass
    jump(16'h0100, 16'h0400, 1, 0, 0, 4, "R9");          // R9 stall after hit, resume T+4
    jump(16'h0120, 16'h0600, 1, 0, 0, 3, "R9");          // R9 stall during fill
    setGen(8'd4);
    jump(16'h0120, 16'h0600, 1, 0, 0, 0, "R9");          // R9 stalled fill captured correctly
    jump(16'h0100, 16'h0400, 1, 0, 0, 0, "R6");          // R6 replaces entry
    jump(16'h0120, 16'h0600, 1, 0, 0, 0, "R6");          // R6 earlier jump now misses
    setGen(8'd6);
    curTag = "R7";
    @(posedge clk); #1 flushSeg = 1; mValid = 0;         // R7 flush alone
    @(posedge clk); #1 flushSeg = 0;
    idle(3);
    jump(16'h0120, 16'h0600, 1, 0, 0, 0, "R7");          // R7 miss after flush
    setGen(8'd7);
    jump(16'h0120, 16'h0600, 1, 0, 1, 0, "R7");          // R7 flush with jump: miss, no fill
    setGen(8'd8);
    jump(16'h0120, 16'h0600, 1, 0, 0, 0, "R7");          // R7 still a miss

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nBad++;
      $display("FAIL watchdog: run did not complete (expected completion)");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule